// File: doc/BRIEF.md
# Four-Bit Calculator Datapath

This block is the data half of a small calculator. An external controller steers it cycle by cycle through three groups of control inputs. The first is a 3-bit source select feeding an eight-way multiplexer. The second is a pair of load enables, one for each register. The third is a 3-bit ALU opcode with a carry-in.

The multiplexer can pick any of these sources:
- the external operand, as is or bitwise inverted;
- the accumulator register B, as is or inverted;
- the working register A, unshifted or shifted by one place (arithmetic right, logical right or logical left).

Its output loads into register A. The ALU combines A (operand X) with B (operand Y). Its result loads into B, and B is the data output. The carry-out is driven straight from the ALU with no register in between.

The inverted paths, the shift paths and the carry-in are primitives. From them the controller builds subtraction, increment, negation and multi-step shift or multiply sequences. The block has no state machine of its own. Its only state is the two registers, and each has exactly two transitions: load or hold. A synchronous reset forces both registers to zero.

Top module: `calc_datapath`

## Requirements
- R1: When `srst` is high at a rising edge, both registers become 0000, even if `ld_a` or `ld_b` is also high; `dout` reads 0000 after that edge.
- R2: When `ld_a` is high (and `srst` low), register A takes the multiplexer output at the rising edge; when `ld_a` is low, A keeps its value whatever `din` or `src_sel` do.
- R3: `src_sel` 000 selects `din`; 001 selects the bitwise inverse of `din`.
- R4: `src_sel` 010 selects register B; 011 selects the bitwise inverse of B.
- R5: `src_sel` 100 selects A shifted right by one with bit 3 copied into bit 3; 101 selects A shifted right by one with a 0 entering bit 3; 110 selects A shifted left by one with a 0 entering bit 0; 111 selects A unchanged.
- R6: `alu_op` 000 gives A + B + `cin`; `cout` is the carry out of bit 3.
- R7: `alu_op` 001 gives A + (inverse of B) + `cin`, so `cin`=1 yields A − B; `cout` is the carry out of bit 3 (1 when no borrow).
- R8: `alu_op` 010 gives A + `cin`; `cout` is the carry out of bit 3.
- R9: `alu_op` 011 passes B and `alu_op` 111 passes A; `cout` is 0 for both.
- R10: `alu_op` 100, 101 and 110 give A OR B, A AND B and A XOR B; `cout` is 0 for all three.
- R11: When `ld_b` is high (and `srst` low), register B takes the ALU result at the rising edge and `dout` shows it after that edge; when `ld_b` is low, `dout` holds.
- R12: `cout` is combinational: it follows `alu_op`, `cin` and the register contents within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high, clears both registers |
| din | input | 4 | External operand |
| src_sel | input | 3 | Multiplexer source select for register A |
| ld_a | input | 1 | Load enable of register A |
| alu_op | input | 3 | ALU operation code |
| cin | input | 1 | ALU carry-in |
| ld_b | input | 1 | Load enable of register B |
| dout | output | 4 | Contents of register B |
| cout | output | 1 | ALU carry-out |

## Verification
Every ALU operation is driven with A and B preloaded through the normal ports. The arithmetic cases cover:
- sums that stay inside four bits;
- sums that wrap, which separate a dropped carry from a kept one;
- subtraction in both operand orders, which separates borrow from no-borrow;
- increment of 1111, which tests wrap and carry together.

The logic operations use the operand pair 1010 and 0110, which gives a different result for OR, AND, XOR and each pass-through. Any swapped opcode therefore shows up.

Each multiplexer source is loaded into A and read back through the pass-A operation. The value 1001 makes arithmetic and logical right shifts give different answers, and it also exposes a lost bit in the left shift.

Separate cases cover three further behaviours:
- a register holds when its enable is low and the inputs change;
- reset wins over both loads at the same edge;
- carry is observed before any load edge, which shows it is not registered.

// File: rtl/calc_pkg.sv
package calc_pkg;

    localparam int unsigned DATA_W = 4;

    typedef enum logic [2:0] {
        SRC_DIN     = 3'b000,
        SRC_DIN_INV = 3'b001,
        SRC_B       = 3'b010,
        SRC_B_INV   = 3'b011,
        SRC_A_ASR   = 3'b100,
        SRC_A_LSR   = 3'b101,
        SRC_A_LSL   = 3'b110,
        SRC_A       = 3'b111
    } src_sel_e;

    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_SUB   = 3'b001,
        OP_INC   = 3'b010,
        OP_PASSY = 3'b011,
        OP_OR    = 3'b100,
        OP_AND   = 3'b101,
        OP_XOR   = 3'b110,
        OP_PASSX = 3'b111
    } alu_op_e;

endpackage

// File: rtl/calc_src_mux.sv
module calc_src_mux
    import calc_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  src_sel_e       sel,
    input  logic [W-1:0]   din,
    input  logic [W-1:0]   reg_a,
    input  logic [W-1:0]   reg_b,
    output logic [W-1:0]   mux_q
);

    localparam int unsigned MSB = W - 1;

    logic [W-1:0] a_asr;
    logic [W-1:0] a_lsr;
    logic [W-1:0] a_lsl;

    // Single-place shifts of A, built generically over the width.
    assign a_asr = {reg_a[MSB], reg_a[MSB:1]};
    assign a_lsr = {1'b0, reg_a[MSB:1]};
    assign a_lsl = {reg_a[MSB-1:0], 1'b0};

    always_comb begin
        unique case (sel)
            SRC_DIN:     mux_q = din;
            SRC_DIN_INV: mux_q = ~din;
            SRC_B:       mux_q = reg_b;
            SRC_B_INV:   mux_q = ~reg_b;
            SRC_A_ASR:   mux_q = a_asr;
            SRC_A_LSR:   mux_q = a_lsr;
            SRC_A_LSL:   mux_q = a_lsl;
            SRC_A:       mux_q = reg_a;
            default:     mux_q = '0;
        endcase
    end

endmodule

// File: rtl/calc_alu.sv
module calc_alu
    import calc_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);

    localparam int unsigned SW = W + 1;

    logic [SW-1:0] sum;
    logic [W-1:0]  addend;
    logic          is_arith;

    // One shared adder; opcode chooses the second addend.
    always_comb begin
        unique case (op)
            OP_ADD:  addend = y;
            OP_SUB:  addend = ~y;
            default: addend = '0;
        endcase
        sum = {1'b0, x} + {1'b0, addend} + SW'(cin);
    end

    always_comb begin
        is_arith = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB, OP_INC: begin
                res      = sum[W-1:0];
                is_arith = 1'b1;
            end
            OP_PASSY: res = y;
            OP_OR:    res = x | y;
            OP_AND:   res = x & y;
            OP_XOR:   res = x ^ y;
            OP_PASSX: res = x;
            default:  res = '0;
        endcase
        cout = is_arith & sum[W];
    end

endmodule

// File: rtl/calc_reg.sv
module calc_reg #(
    parameter int unsigned W = 4
) (
    input  logic           clk,
    input  logic           srst,
    input  logic           load,
    input  logic [W-1:0]   d,
    output logic [W-1:0]   q
);

    // Two transitions only: LOAD or HOLD; reset overrides both.
    always_ff @(posedge clk) begin
        if (srst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/calc_datapath.sv
module calc_datapath
    import calc_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic           clk,
    input  logic           srst,
    input  logic [W-1:0]   din,
    input  logic [2:0]     src_sel,
    input  logic           ld_a,
    input  logic [2:0]     alu_op,
    input  logic           cin,
    input  logic           ld_b,
    output logic [W-1:0]   dout,
    output logic           cout
);

    logic [W-1:0] ra_q;
    logic [W-1:0] rb_q;
    logic [W-1:0] mux_q;
    logic [W-1:0] alu_res;

    calc_src_mux #(.W(W)) u_mux (
        .sel   (src_sel_e'(src_sel)),
        .din   (din),
        .reg_a (ra_q),
        .reg_b (rb_q),
        .mux_q (mux_q)
    );

    calc_reg #(.W(W)) u_reg_a (
        .clk  (clk),
        .srst (srst),
        .load (ld_a),
        .d    (mux_q),
        .q    (ra_q)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(srst) |-> (ra_q == '0 && rb_q == '0));

    // R2
    ra_load_chk: assert property (@(posedge clk) disable iff (srst)
        ($past(ld_a) && !$past(srst)) |-> (ra_q == $past(mux_q)));

    // R2
    ra_hold_chk: assert property (@(posedge clk) disable iff (srst)
        (!$past(ld_a) && !$past(srst)) |-> $stable(ra_q));

    calc_alu #(.W(W)) u_alu (
        .op   (alu_op_e'(alu_op)),
        .x    (ra_q),
        .y    (rb_q),
        .cin  (cin),
        .res  (alu_res),
        .cout (cout)
    );

    // R9 R10
    logic_cout_chk: assert property (@(posedge clk) disable iff (srst)
        (alu_op >= 3'd3) |-> !cout);

    calc_reg #(.W(W)) u_reg_b (
        .clk  (clk),
        .srst (srst),
        .load (ld_b),
        .d    (alu_res),
        .q    (rb_q)
    );

    assign dout = rb_q;

    // R11
    rb_load_chk: assert property (@(posedge clk) disable iff (srst)
        ($past(ld_b) && !$past(srst)) |-> (dout == $past(alu_res)));

    // R11
    rb_hold_chk: assert property (@(posedge clk) disable iff (srst)
        (!$past(ld_b) && !$past(srst)) |-> $stable(dout));

endmodule

// File: tb/calc_datapath_bench.sv
module calc_datapath_bench;

    logic       clk = 1'b0;
    logic       srst;
    logic [3:0] din;
    logic [2:0] src_sel;
    logic       ld_a;
    logic [2:0] alu_op;
    logic       cin;
    logic       ld_b;
    logic [3:0] dout;
    logic       cout;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    calc_datapath u_calc_datapath (
        .clk     (clk),
        .srst    (srst),
        .din     (din),
        .src_sel (src_sel),
        .ld_a    (ld_a),
        .alu_op  (alu_op),
        .cin     (cin),
        .ld_b    (ld_b),
        .dout    (dout),
        .cout    (cout)
    );

    // Vector layout: a[16:13] b[12:9] op[8:6] cin[5] res[4:1] cout[0]
    localparam int NV = 11;
    localparam logic [16:0] VEC [NV] = '{
        {4'h3, 4'h5, 3'd0, 1'b0, 4'h8, 1'b0},  // R6 no wrap
        {4'h9, 4'h8, 3'd0, 1'b1, 4'h2, 1'b1},  // R6 wrap with carry
        {4'h7, 4'h3, 3'd1, 1'b1, 4'h4, 1'b1},  // R7 no borrow
        {4'h3, 4'h7, 3'd1, 1'b1, 4'hC, 1'b0},  // R7 borrow
        {4'hF, 4'h0, 3'd2, 1'b1, 4'h0, 1'b1},  // R8 wrap
        {4'h6, 4'h0, 3'd2, 1'b0, 4'h6, 1'b0},  // R8 cin low
        {4'hA, 4'h5, 3'd3, 1'b1, 4'h5, 1'b0},  // R9 pass B
        {4'hA, 4'h6, 3'd4, 1'b1, 4'hE, 1'b0},  // R10 OR
        {4'hA, 4'h6, 3'd5, 1'b0, 4'h2, 1'b0},  // R10 AND
        {4'hA, 4'h6, 3'd6, 1'b1, 4'hC, 1'b0},  // R10 XOR
        {4'hA, 4'h6, 3'd7, 1'b1, 4'hA, 1'b0}   // R9 pass A
    };

    task automatic check(input logic [3:0] act, input logic [3:0] exp,
                         input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ld_a = 1'b0;
        ld_b = 1'b0;
        srst = 1'b0;
    endtask

    // Preload B via pass-A, then A from din.
    task automatic set_ab(input logic [3:0] a, input logic [3:0] b);
        din = b; src_sel = 3'd0; ld_a = 1'b1; ld_b = 1'b0;
        @(negedge clk);
        ld_a = 1'b0; alu_op = 3'd7; ld_b = 1'b1;
        @(negedge clk);
        ld_b = 1'b0; din = a; ld_a = 1'b1;
        @(negedge clk);
        ld_a = 1'b0;
    endtask

    task automatic read_a(output logic [3:0] val);
        alu_op = 3'd7; ld_b = 1'b1;
        @(negedge clk);
        ld_b = 1'b0;
        val = dout;
    endtask

    task automatic sel_case(input logic [3:0] a, input logic [3:0] b,
                            input logic [3:0] d, input logic [2:0] s,
                            input logic [3:0] exp, input string tag);
        logic [3:0] got;
        set_ab(a, b);
        din = d; src_sel = s; ld_a = 1'b1;
        @(negedge clk);
        ld_a = 1'b0;
        read_a(got);
        check(got, exp, tag);
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [3:0] got;
        srst = 1'b1; din = 4'h0; src_sel = 3'd0; ld_a = 1'b0;
        alu_op = 3'd0; cin = 1'b0; ld_b = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(dout, 4'h0, "R1 reset state");
        idle();

        // Vector table: cout checked before the load edge (R12), result after.
        for (int i = 0; i < NV; i++) begin
            set_ab(VEC[i][16:13], VEC[i][12:9]);
            alu_op = VEC[i][8:6];
            cin    = VEC[i][5];
            #1;
            check({3'b0, cout}, {3'b0, VEC[i][0]}, $sformatf("R12 cout vec%0d", i));
            ld_b = 1'b1;
            @(negedge clk);
            ld_b = 1'b0;
            check(dout, VEC[i][4:1], $sformatf("R11 result vec%0d op%0d", i, VEC[i][8:6]));
        end
        cin = 1'b0;

        // Multiplexer sources
        sel_case(4'h0, 4'h0, 4'h6, 3'd0, 4'h6, "R3 din");
        sel_case(4'h0, 4'h0, 4'h6, 3'd1, 4'h9, "R3 inverted din");
        sel_case(4'h0, 4'hC, 4'h0, 3'd2, 4'hC, "R4 B");
        sel_case(4'h0, 4'hC, 4'h0, 3'd3, 4'h3, "R4 inverted B");
        sel_case(4'h9, 4'h0, 4'h0, 3'd4, 4'hC, "R5 asr 1001");
        sel_case(4'h5, 4'h0, 4'h0, 3'd4, 4'h2, "R5 asr 0101");
        sel_case(4'h9, 4'h0, 4'h0, 3'd5, 4'h4, "R5 lsr");
        sel_case(4'h9, 4'h0, 4'h0, 3'd6, 4'h2, "R5 lsl");
        sel_case(4'h9, 4'h0, 4'h0, 3'd7, 4'h9, "R5 unshifted A");

        // R2 hold: A unchanged with ld_a low
        set_ab(4'h5, 4'h3);
        din = 4'hE; src_sel = 3'd0; ld_a = 1'b0;
        @(negedge clk);
        read_a(got);
        check(got, 4'h5, "R2 A hold");

        // R11 hold: dout unchanged with ld_b low
        set_ab(4'h5, 4'h3);
        alu_op = 3'd0; cin = 1'b1; ld_b = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(dout, 4'h3, "R11 B hold");
        cin = 1'b0;

        // R1 priority over both loads
        set_ab(4'h7, 4'h6);
        din = 4'hF; src_sel = 3'd0; alu_op = 3'd7;
        ld_a = 1'b1; ld_b = 1'b1; srst = 1'b1;
        @(negedge clk);
        idle();
        check(dout, 4'h0, "R1 reset beats ld_b");
        read_a(got);
        check(got, 4'h0, "R1 reset beats ld_a");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule